// File: doc/BRIEF.md
# Lazy Clock-Constraint Signal Cache

This block keeps a table of 32 one-bit signals, each with a valid flag, addressed by a 5-bit index. A policy-state entry pulse (`load_i`) refreshes the table. Entries that a mask marks as pin signals take their value from a pin bus and become valid at once. Entries that the mask marks as clock constraints are left invalid. They are computed only when something asks for them.

A requester raises `req_i` with an index and holds it until `ready_o` is high. A valid entry answers in the same cycle. An invalid entry starts a fetch of its constraint encoding from a byte memory, at the address equal to the index. The encoding is one byte when its top bit is 0 and two bytes when its top bit is 1. The block compares the selected clock counter with the immediate, stores the result, marks the entry valid, and answers the still-held request on the next cycle. Results stay cached until the next `load_i`.

The controller has three states. `S_IDLE` serves hits and, on a miss, moves to `S_HEAD` (`IDLE->HEAD`). `S_HEAD` reads the first byte. A short encoding is evaluated and written there (`HEAD->IDLE`); a long one is captured (`HEAD->TAIL`). `S_TAIL` reads the second byte, evaluates, writes and returns (`TAIL->IDLE`). `load_i` sends every state to `S_IDLE`.

Top module: `lazy_cc_cache`

## Requirements
- R1: After reset, `busy_o` and `ready_o` are 0 and every table entry is invalid.
- R2: On `load_i`, every entry whose bit in `clk_mask_i` is 0 takes the matching bit of `pin_vals_i` and becomes valid. A request to such an entry gives `ready_o`=1 and `sig_o` in the same cycle, with `busy_o` staying 0.
- R3: On `load_i`, every entry whose mask bit is 1 becomes invalid. A request to an invalid entry sets `busy_o` one cycle later, and `mem_addr_o` then equals the requested index.
- R4: A first byte with bit 7 = 0 is a short constraint, laid out as {0, op, c[1:0], imm[3:0]}. It compares bits [3:0] of clock number {c,0} with imm. The result is ready two cycles after the request is first seen.
- R5: A first byte with bit 7 = 1 is a long constraint, laid out as {1, op, c[1:0], imm[3:0]}. The byte at index+1 supplies the low 8 bits. The 12-bit immediate {imm, byte2} is compared with the full 12-bit clock number {c,1}. The result is ready three cycles after the request.
- R6: Bit 6 (op) selects the test: 1 means clock equals immediate, 0 means clock is less than immediate.
- R7: An evaluated entry stays valid, and a repeat request to it answers in the same cycle without a memory access.
- R8: A later `load_i` invalidates clock entries again, so a new request recomputes them against the current clock values.
- R9: When `load_i` falls in the same cycle as a constraint result write, the load wins and the entry stays invalid.
- R10: `load_i` during a fetch aborts it: `busy_o` is 0 in the following cycle.
- R11: `ready_o` is 0 while `load_i` is high and while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Policy-state entry pulse |
| pin_vals_i | input | 32 | Pin signal values |
| clk_mask_i | input | 32 | 1 marks an entry as a clock constraint |
| req_i | input | 1 | Signal request, held until ready |
| req_idx_i | input | 5 | Requested signal index |
| ready_o | output | 1 | Requested signal is valid this cycle |
| sig_o | output | 1 | Value of requested signal |
| busy_o | output | 1 | Constraint fetch in progress |
| mem_addr_o | output | 8 | Byte memory read address |
| mem_rdata_i | input | 8 | Byte memory read data (combinational read) |
| clocks_i | input | 96 | Eight 12-bit clock counters, clock 0 in the low bits |

## Verification
Two functions can land in the same cycle: the write of a freshly evaluated constraint result and the invalidating table load. The bench provokes this by raising `load_i` during the head-read cycle of a short-constraint miss. It then requests the same index again and requires a full two-cycle miss rather than a same-cycle hit. A related case raises `load_i` during the head read of a long constraint. There, `busy_o` must be low the next cycle instead of entering the tail read.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_TAIL = 2'd2
    } lcc_state_e;

    localparam int FMT_LONG_BIT = 7;
    localparam int FMT_OP_BIT   = 6;
    localparam int FMT_CLK_HI   = 5;
    localparam int FMT_CLK_LO   = 4;
    localparam int FMT_IMM_W    = 4;
endpackage

// File: rtl/lcc_table.sv
module lcc_table #(
    parameter int N_SIG = 32,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [N_SIG-1:0] pin_vals_i,
    input  logic [N_SIG-1:0] clk_mask_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic             rd_data_o
);
    logic [N_SIG-1:0] valid_q;
    logic [N_SIG-1:0] data_q;

    // load has priority over a result write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            data_q  <= '0;
        end else if (load_i) begin
            valid_q <= ~clk_mask_i;
            data_q  <= pin_vals_i & ~clk_mask_i;
        end else if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
            data_q[wr_idx_i]  <= wr_data_i;
        end
    end

    assign rd_valid_o = valid_q[rd_idx_i];
    assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/lcc_compare.sv
module lcc_compare #(
    parameter int N_CLK = 8,
    parameter int CLK_W = 12,
    localparam int SEL_W = $clog2(N_CLK)
) (
    input  logic [7:0]             head_i,
    input  logic [7:0]             tail_i,
    input  logic                   long_i,
    input  logic [N_CLK*CLK_W-1:0] clocks_i,
    output logic                   result_o
);
    import lcc_pkg::*;

    logic [SEL_W-1:0] sel;
    logic [CLK_W-1:0] cval;
    logic [CLK_W-1:0] imm_long;
    logic [FMT_IMM_W-1:0] imm_short;
    logic             op_eq;

    always_comb begin
        sel       = SEL_W'({head_i[FMT_CLK_HI:FMT_CLK_LO], long_i});
        cval      = clocks_i[int'(sel)*CLK_W +: CLK_W];
        imm_short = head_i[FMT_IMM_W-1:0];
        imm_long  = CLK_W'({head_i[FMT_IMM_W-1:0], tail_i});
        op_eq     = head_i[FMT_OP_BIT];
        if (long_i)
            result_o = op_eq ? (cval == imm_long) : (cval < imm_long);
        else
            result_o = op_eq ? (cval[FMT_IMM_W-1:0] == imm_short)
                             : (cval[FMT_IMM_W-1:0] < imm_short);
    end
endmodule

// File: rtl/lcc_fsm.sv
module lcc_fsm #(
    parameter int N_SIG  = 32,
    parameter int MEM_AW = 8,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              req_i,
    input  logic [IDX_W-1:0]  req_idx_i,
    input  logic              hit_valid_i,
    input  logic [7:0]        mem_rdata_i,
    input  logic              cmp_res_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [7:0]        cmp_head_o,
    output logic [7:0]        cmp_tail_o,
    output logic              cmp_long_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o
);
    import lcc_pkg::*;

    lcc_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       head_q;
    logic             is_long;

    assign is_long = mem_rdata_i[FMT_LONG_BIT];

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_i && !hit_valid_i) state_d = S_HEAD;
                S_HEAD: state_d = is_long ? S_TAIL : S_IDLE;
                S_TAIL: state_d = S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_i) idx_q <= req_idx_i;
            if (state_q == S_HEAD) head_q <= mem_rdata_i;
        end
    end

    always_comb begin
        busy_o     = 1'b0;
        ready_o    = 1'b0;
        mem_addr_o = MEM_AW'(idx_q);
        cmp_head_o = mem_rdata_i;
        cmp_tail_o = 8'h00;
        cmp_long_o = 1'b0;
        wr_en_o    = 1'b0;
        wr_idx_o   = idx_q;
        unique case (state_q)
            S_IDLE: ready_o = req_i && hit_valid_i && !load_i;
            S_HEAD: begin
                busy_o  = 1'b1;
                wr_en_o = !is_long;
            end
            S_TAIL: begin
                busy_o     = 1'b1;
                mem_addr_o = MEM_AW'(idx_q) + MEM_AW'(1);
                cmp_head_o = head_q;
                cmp_tail_o = mem_rdata_i;
                cmp_long_o = 1'b1;
                wr_en_o    = 1'b1;
            end
            default: busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lazy_cc_cache.sv
module lazy_cc_cache #(
    parameter int N_SIG  = 32,
    parameter int N_CLK  = 8,
    parameter int CLK_W  = 12,
    parameter int MEM_AW = 8,
    localparam int IDX_W = $clog2(N_SIG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [N_SIG-1:0]       pin_vals_i,
    input  logic [N_SIG-1:0]       clk_mask_i,
    input  logic                   req_i,
    input  logic [IDX_W-1:0]       req_idx_i,
    output logic                   ready_o,
    output logic                   sig_o,
    output logic                   busy_o,
    output logic [MEM_AW-1:0]      mem_addr_o,
    input  logic [7:0]             mem_rdata_i,
    input  logic [N_CLK*CLK_W-1:0] clocks_i
);
    logic             hit_valid;
    logic             cmp_res;
    logic [7:0]       cmp_head;
    logic [7:0]       cmp_tail;
    logic             cmp_long;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    lcc_table #(.N_SIG(N_SIG)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .pin_vals_i (pin_vals_i),
        .clk_mask_i (clk_mask_i),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (cmp_res),
        .rd_idx_i   (req_idx_i),
        .rd_valid_o (hit_valid),
        .rd_data_o  (sig_o)
    );

    lcc_compare #(.N_CLK(N_CLK), .CLK_W(CLK_W)) u_cmp (
        .head_i   (cmp_head),
        .tail_i   (cmp_tail),
        .long_i   (cmp_long),
        .clocks_i (clocks_i),
        .result_o (cmp_res)
    );

    lcc_fsm #(.N_SIG(N_SIG), .MEM_AW(MEM_AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .req_i       (req_i),
        .req_idx_i   (req_idx_i),
        .hit_valid_i (hit_valid),
        .mem_rdata_i (mem_rdata_i),
        .cmp_res_i   (cmp_res),
        .busy_o      (busy_o),
        .ready_o     (ready_o),
        .mem_addr_o  (mem_addr_o),
        .cmp_head_o  (cmp_head),
        .cmp_tail_o  (cmp_tail),
        .cmp_long_o  (cmp_long),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx)
    );
endmodule

// File: rtl/lazy_cc_cache_chk.sv
module lazy_cc_cache_chk #(
    parameter int IDX_W  = 5,
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              req_i,
    input logic [IDX_W-1:0]  req_idx_i,
    input logic              ready_o,
    input logic              busy_o,
    input logic [MEM_AW-1:0] mem_addr_o
);
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!busy_o && !load_i)); // R11

    AST_MISS_STARTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && !ready_o && !load_i) |=> busy_o); // R3

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (mem_addr_o == MEM_AW'($past(req_idx_i)))); // R3

    AST_LOAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !busy_o); // R10

    AST_FETCH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |=> !busy_o); // R5
endmodule

bind lazy_cc_cache lazy_cc_cache_chk #(.IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .req_i      (req_i),
    .req_idx_i  (req_idx_i),
    .ready_o    (ready_o),
    .busy_o     (busy_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/lazy_cc_cache_tb.sv
module lazy_cc_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] pin_vals_i = '0;
    logic [31:0] clk_mask_i = '0;
    logic        req_i = 1'b0;
    logic [4:0]  req_idx_i = '0;
    logic        ready_o, sig_o, busy_o;
    logic [7:0]  mem_addr_o;
    logic [7:0]  mem_rdata_i;
    logic [95:0] clocks_i;
    logic [7:0]  mem [256];
    logic [11:0] clk_val [8];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign mem_rdata_i = mem[mem_addr_o];
    for (genvar g = 0; g < 8; g++) begin : g_clk
        assign clocks_i[g*12 +: 12] = clk_val[g];
    end

    lazy_cc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .pin_vals_i(pin_vals_i),
        .clk_mask_i(clk_mask_i), .req_i(req_i), .req_idx_i(req_idx_i),
        .ready_o(ready_o), .sig_o(sig_o), .busy_o(busy_o),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i), .clocks_i(clocks_i)
    );

    // {idx[4:0], expected value, latency[1:0]}
    localparam logic [7:0] VEC [11] = '{
        8'h06, 8'h04, 8'h0E, 8'h17, 8'h27, 8'h32,
        8'h18, 8'h2C, 8'h44, 8'hFC, 8'h14
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_req(input logic [4:0] idx, input bit exp, input int lat, input string tag);
        int n;
        @(negedge clk);
        req_i = 1'b1;
        req_idx_i = idx;
        #1;
        n = 0;
        while (!ready_o && n < 8) begin
            if (n == 1) chk(busy_o && mem_addr_o == 8'(idx), "R3", int'(mem_addr_o), int'(idx));
            @(negedge clk);
            #1;
            n++;
        end
        chk(n == lat, tag, n, lat);
        chk(sig_o == exp, tag, int'(sig_o), int'(exp));
        req_i = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[0] = 8'h55; // short eq, clock 2, imm 5
        mem[1] = 8'h29; // short lt, clock 4, imm 9
        mem[2] = 8'hCA; // long eq, clock 1, imm 0xA..
        mem[3] = 8'hBC;
        mem[4] = 8'hB1; // long lt, clock 7, imm 0x1..
        mem[5] = 8'h00;
        mem[6] = 8'h00; // short lt, clock 0, imm 0
        for (int i = 0; i < 8; i++) clk_val[i] = 12'h000;
        clk_val[0] = 12'h123;
        clk_val[1] = 12'hABC;
        clk_val[2] = 12'h7F5;
        clk_val[4] = 12'h008;
        clk_val[7] = 12'h0FF;
        pin_vals_i = 32'hA5A5_A5A5;
        clk_mask_i = 32'h0000_0057;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !ready_o, "R1", int'({busy_o, ready_o}), 0);
        // R1: before any load, a pin index is invalid and misses
        do_req(5'd8, 1'b0, 2, "R1");

        do_load();
        for (int v = 0; v < 11; v++) begin
            logic [4:0] idx;
            int lat;
            string tag;
            idx = VEC[v][7:3];
            lat = int'(VEC[v][1:0]);
            if (lat == 2) tag = "R4";
            else if (lat == 3) tag = "R5";
            else if (clk_mask_i[idx]) tag = "R7";
            else tag = "R2";
            do_req(idx, VEC[v][2], lat, tag);
        end
        // R6: less-than with clock equal to immediate gives 0
        clk_val[4] = 12'h009;
        clk_val[2] = 12'h004;
        clk_val[1] = 12'hABD;
        clk_val[7] = 12'h100;
        do_load();
        do_req(5'd1, 1'b0, 2, "R6");
        do_req(5'd0, 1'b0, 2, "R8");
        do_req(5'd2, 1'b0, 3, "R8");
        do_req(5'd4, 1'b0, 3, "R6");

        // R9: load coincides with a short result write
        do_load();
        @(negedge clk);
        req_i = 1'b1;
        req_idx_i = 5'd0;
        @(negedge clk);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        req_i = 1'b0;
        do_req(5'd0, 1'b0, 2, "R9");

        // R10: load during a long head read aborts the fetch
        @(negedge clk);
        req_i = 1'b1;
        req_idx_i = 5'd2;
        @(negedge clk);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        req_i = 1'b0;
        #1;
        chk(!busy_o, "R10", int'(busy_o), 0);

        // R11: no ready while load is high, even for a pin hit
        @(negedge clk);
        req_i = 1'b1;
        req_idx_i = 5'd8;
        load_i = 1'b1;
        #1;
        chk(!ready_o, "R11", int'(ready_o), 0);
        @(negedge clk);
        load_i = 1'b0;
        #1;
        chk(ready_o && sig_o, "R11", int'({ready_o, sig_o}), 3);
        req_i = 1'b0;

        repeat (2) @(negedge clk);
        report();
    end
endmodule